// File: doc/BRIEF.md
# DQS Gate System Latency Leveler

After read-gate training, each byte lane of the memory PHY holds a packed gate-timing word. That word carries one small system-latency count for each rank. This block walks those lane words one per cycle and picks out the trained latencies. It finds the smallest and the largest of them and reports when they disagree. It then folds the largest value into the memory controller's read-latency setting.

The controller's read latency is held in two 4-bit fields of its read data control word. One is a primary field and the other is an overflow field, and the effective latency is their sum. The controller runs at half the PHY clock, so the PHY latency is added with its least significant bit cleared. The new total is split back across the two fields, and the updated word is written to both data-slice copies of the control register. All other bits of the word are left unchanged.

A single `start` pulse runs one pass. The block reads lanes through an index/data port and the control word through a read port. It writes back through a write port with a copy select, and it reports `done` together with the result flags.

Top module: `dqs_gate_leveler`

## Requirements
- R1: After reset, `busy`, `done`, `ctlWrEn`, `notLeveled`, `noTrained` and `gateLat` are all zero.
- R2: A pass started by `start` reads every lane index from 0 to DATA_W/8-1. With DATA_W=32 that is four lanes, and a latency found only in the last lane still sets the result.
- R3: Within a lane word, rank r's latency sits in bits [3r+2:3r] for r = 0..3.
- R4: A rank latency of 0 means the rank is untrained. It is left out of both the minimum and the maximum.
- R5: `gateLat` reports the largest nonzero rank latency. `notLeveled` is 1 exactly when the smallest and largest nonzero latencies differ.
- R6: When every rank latency is 0, `noTrained` is 1, `notLeveled` is 0, `gateLat` is 0 and nothing is added to the read latency.
- R7: The new total is bits [7:4] plus bits [11:8] of the control word read back, plus `gateLat` with its bit 0 cleared.
- R8: If the total exceeds 15, bits [7:4] become 15 and bits [11:8] become the total minus 15, capped at 15. Otherwise bits [7:4] hold the total and bits [11:8] are 0.
- R9: Every control-word bit outside [11:4] is written back with the value that was read.
- R10: Each pass writes exactly twice, on consecutive cycles: first copy 0 (`ctlWrSel`=0), then copy 1 (`ctlWrSel`=1), with the same word both times. `done` is high for the one cycle after the second write.
- R11: A `start` pulse that arrives while `busy` is high is ignored. The pass still performs exactly two writes, with the result of the original scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one leveling pass (ignored while busy) |
| laneRdIdx | output | LANE_IDX_W | Byte-lane index being read |
| laneRdData | input | LANE_WORD_W | Gate-timing word of the indexed lane, same cycle |
| ctlRdData | input | CTL_W | Current read data control word (copy 0) |
| ctlWrEn | output | 1 | Control word write strobe |
| ctlWrSel | output | 1 | Which data-slice copy is written (0 or 1) |
| ctlWrData | output | CTL_W | Updated control word |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| gateLat | output | RLAT_W | Largest trained rank latency of the last pass |
| notLeveled | output | 1 | Trained rank latencies were not all equal |
| noTrained | output | 1 | No rank latency was nonzero |

## Verification
Several properties are checked by assertions on every cycle:
- the two write strobes arrive back to back with an unchanged word, and `done` follows them;
- a written word never pairs a non-saturated primary field with a nonzero overflow field;
- the bits outside the latency fields match the word that was read;
- the running minimum never exceeds the running maximum once a trained rank has been seen.

Other behaviour can only be shown by the bench's sweeps, because only they know the expected arithmetic:
- that zero ranks are really skipped;
- that bit 0 of the PHY latency is dropped;
- that the spill into the overflow field is correct across all 256 starting field pairs;
- that a second `start` during a pass leaves the result untouched.

// File: rtl/dqs_gate_lvl_pkg.sv
package dqs_gate_lvl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_CALC,
    ST_WR0,
    ST_WR1,
    ST_FIN
  } lvlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;      // restart min/max accumulation
    logic capture;    // fold the current lane word in
    logic latchWord;  // compute and hold the updated control word
    logic publish;    // expose the result flags
  } lvlStrobes_t;

endpackage

// File: rtl/dqs_gate_lvl_ctrl.sv
module dqs_gate_lvl_ctrl
  import dqs_gate_lvl_pkg::*;
#(
  parameter int LANE_CNT   = 4,
  parameter int LANE_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic [LANE_IDX_W-1:0] laneIdx,
  output lvlStrobes_t           strobes,
  output logic                  wrEn,
  output logic                  wrSel,
  output logic                  busy,
  output logic                  done
);

  localparam logic [LANE_IDX_W-1:0] LAST_LANE = LANE_IDX_W'(LANE_CNT - 1);

  lvlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_SCAN;
      ST_SCAN: if (laneIdx == LAST_LANE) stateNext = ST_CALC;
      ST_CALC: stateNext = ST_WR0;
      ST_WR0:  stateNext = ST_WR1;
      ST_WR1:  stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      laneIdx <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE)
        laneIdx <= '0;
      else if (state == ST_SCAN && laneIdx != LAST_LANE)
        laneIdx <= laneIdx + 1'b1;
    end
  end

  always_comb begin
    strobes.clear     = (state == ST_IDLE) && start;
    strobes.capture   = (state == ST_SCAN);
    strobes.latchWord = (state == ST_CALC);
    strobes.publish   = (state == ST_WR1);
  end

  assign wrEn = (state == ST_WR0) || (state == ST_WR1);
  assign wrSel = (state == ST_WR1);
  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R10
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && !wrSel |=> wrEn && wrSel);

  // R10
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && wrSel |=> done && !wrEn);

  // R2
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> strobes.capture && laneIdx == '0);

endmodule

// File: rtl/dqs_gate_lvl_datapath.sv
module dqs_gate_lvl_datapath
  import dqs_gate_lvl_pkg::*;
#(
  parameter int LANE_WORD_W = 32,
  parameter int RANK_CNT    = 4,
  parameter int RLAT_W      = 3,
  parameter int CTL_W       = 32,
  parameter int FIELD_W     = 4,
  parameter int PRI_LSB     = 4,
  parameter int OVF_LSB     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  lvlStrobes_t            strobes,
  input  logic [LANE_WORD_W-1:0] laneWord,
  input  logic [CTL_W-1:0]       ctlRdData,
  output logic [CTL_W-1:0]       newWord,
  output logic [RLAT_W-1:0]      gateLat,
  output logic                   notLeveled,
  output logic                   noTrained
);

  localparam int SUM_W = ((FIELD_W > RLAT_W) ? FIELD_W : RLAT_W) + 2;
  localparam logic [SUM_W-1:0] FIELD_MAX = SUM_W'((1 << FIELD_W) - 1);
  localparam logic [CTL_W-1:0] FIELD_MASK =
    CTL_W'(((1 << FIELD_W) - 1) << PRI_LSB) | CTL_W'(((1 << FIELD_W) - 1) << OVF_LSB);

  logic [RANK_CNT-1:0][RLAT_W-1:0] rankLat;
  logic [RANK_CNT-1:0]             rankValid;

  genvar r;
  generate
    for (r = 0; r < RANK_CNT; r++) begin : g_rank
      assign rankLat[r]   = laneWord[r*RLAT_W +: RLAT_W];
      assign rankValid[r] = |rankLat[r];
    end
  endgenerate

  logic [RLAT_W-1:0] laneMin, laneMax;
  always_comb begin
    laneMin = '1;
    laneMax = '0;
    for (int i = 0; i < RANK_CNT; i++) begin
      if (rankValid[i]) begin
        if (rankLat[i] < laneMin) laneMin = rankLat[i];
        if (rankLat[i] > laneMax) laneMax = rankLat[i];
      end
    end
  end

  logic [RLAT_W-1:0] minReg, maxReg;
  logic              anyReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      minReg <= '1;
      maxReg <= '0;
      anyReg <= 1'b0;
    end else if (strobes.clear) begin
      minReg <= '1;
      maxReg <= '0;
      anyReg <= 1'b0;
    end else if (strobes.capture) begin
      if (|rankValid) begin
        if (laneMin < minReg) minReg <= laneMin;
        if (laneMax > maxReg) maxReg <= laneMax;
        anyReg <= 1'b1;
      end
    end
  end

  // read latency arithmetic
  logic [SUM_W-1:0] curLat, phyLat, total, spill;
  logic [FIELD_W-1:0] priField, ovfField;

  always_comb begin
    curLat = SUM_W'(ctlRdData[PRI_LSB +: FIELD_W]) + SUM_W'(ctlRdData[OVF_LSB +: FIELD_W]);
    phyLat = SUM_W'({maxReg[RLAT_W-1:1], 1'b0});
    total  = curLat + phyLat;
    spill  = total - FIELD_MAX;
    if (total > FIELD_MAX) begin
      priField = FIELD_W'(FIELD_MAX);
      ovfField = (spill > FIELD_MAX) ? FIELD_W'(FIELD_MAX) : FIELD_W'(spill);
    end else begin
      priField = FIELD_W'(total);
      ovfField = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      newWord <= '0;
    end else if (strobes.latchWord) begin
      newWord <= ctlRdData;
      newWord[PRI_LSB +: FIELD_W] <= priField;
      newWord[OVF_LSB +: FIELD_W] <= ovfField;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateLat    <= '0;
      notLeveled <= 1'b0;
      noTrained  <= 1'b0;
    end else if (strobes.publish) begin
      gateLat    <= maxReg;
      notLeveled <= anyReg && (minReg != maxReg);
      noTrained  <= !anyReg;
    end
  end

  // R4
  min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anyReg |-> (minReg <= maxReg) && (maxReg != '0));

  // R6
  untrained_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !anyReg |-> maxReg == '0);

  // R9
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.latchWord |=> ((newWord ^ $past(ctlRdData)) & ~FIELD_MASK) == '0);

endmodule

// File: rtl/dqs_gate_leveler.sv
module dqs_gate_leveler
  import dqs_gate_lvl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LANE_WORD_W = 32,
  parameter int RANK_CNT    = 4,
  parameter int RLAT_W      = 3,
  parameter int CTL_W       = 32,
  parameter int FIELD_W     = 4,
  parameter int PRI_LSB     = 4,
  parameter int OVF_LSB     = 8,
  localparam int LANE_CNT   = DATA_W / 8,
  localparam int LANE_IDX_W = (LANE_CNT > 1) ? $clog2(LANE_CNT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic [LANE_IDX_W-1:0]  laneRdIdx,
  input  logic [LANE_WORD_W-1:0] laneRdData,
  input  logic [CTL_W-1:0]       ctlRdData,
  output logic                   ctlWrEn,
  output logic                   ctlWrSel,
  output logic [CTL_W-1:0]       ctlWrData,
  output logic                   busy,
  output logic                   done,
  output logic [RLAT_W-1:0]      gateLat,
  output logic                   notLeveled,
  output logic                   noTrained
);

  lvlStrobes_t strobes;

  dqs_gate_lvl_ctrl #(
    .LANE_CNT  (LANE_CNT),
    .LANE_IDX_W(LANE_IDX_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .laneIdx(laneRdIdx),
    .strobes(strobes),
    .wrEn   (ctlWrEn),
    .wrSel  (ctlWrSel),
    .busy   (busy),
    .done   (done)
  );

  dqs_gate_lvl_datapath #(
    .LANE_WORD_W(LANE_WORD_W),
    .RANK_CNT   (RANK_CNT),
    .RLAT_W     (RLAT_W),
    .CTL_W      (CTL_W),
    .FIELD_W    (FIELD_W),
    .PRI_LSB    (PRI_LSB),
    .OVF_LSB    (OVF_LSB)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .laneWord  (laneRdData),
    .ctlRdData (ctlRdData),
    .newWord   (ctlWrData),
    .gateLat   (gateLat),
    .notLeveled(notLeveled),
    .noTrained (noTrained)
  );

  // R10
  same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWrEn && !ctlWrSel |=> $stable(ctlWrData));

  // R8
  field_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWrEn |-> (ctlWrData[PRI_LSB +: FIELD_W] == '1) || (ctlWrData[OVF_LSB +: FIELD_W] == '0));

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(notLeveled && noTrained));

endmodule

// File: tb/dqs_gate_leveler_tb.sv
module dqs_gate_leveler_tb;

  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  laneRdIdx;
  logic [31:0] laneRdData;
  logic [31:0] ctlRdData;
  logic        ctlWrEn, ctlWrSel, busy, done, notLeveled, noTrained;
  logic [31:0] ctlWrData;
  logic [2:0]  gateLat;

  logic [31:0] gtr [LANES];
  logic [31:0] ctlInit = '0;
  logic [31:0] wr0Data = '0, wr1Data = '0;
  int          wrTotal = 0;
  int          nChecks = 0, nFails = 0, cycles = 0;
  logic [31:0] seed = 32'h1ace_b00c;

  always #4 clk = ~clk;

  assign laneRdData = gtr[laneRdIdx];
  assign ctlRdData  = ctlInit;

  dqs_gate_leveler u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .laneRdIdx(laneRdIdx), .laneRdData(laneRdData), .ctlRdData(ctlRdData),
    .ctlWrEn(ctlWrEn), .ctlWrSel(ctlWrSel), .ctlWrData(ctlWrData),
    .busy(busy), .done(done), .gateLat(gateLat),
    .notLeveled(notLeveled), .noTrained(noTrained)
  );

  always @(posedge clk) begin
    if (rst_n && ctlWrEn) begin
      if (ctlWrSel) wr1Data <= ctlWrData;
      else          wr0Data <= ctlWrData;
      wrTotal <= wrTotal + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [31:0] nextRnd(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected result computed from the requirements (R3..R8)
  task automatic model(output logic [31:0] word, output bit nl, output bit nt, output int mx);
    int mn, v, tot, p, o;
    mn = 8; mx = 0;
    for (int l = 0; l < LANES; l++)
      for (int r = 0; r < 4; r++) begin
        v = int'((gtr[l] >> (3 * r)) & 32'h7);
        if (v != 0) begin
          if (v < mn) mn = v;
          if (v > mx) mx = v;
        end
      end
    nt = (mx == 0);
    nl = !nt && (mn != mx);
    tot = int'(ctlInit[7:4]) + int'(ctlInit[11:8]) + (mx & 6);
    if (tot > 15) begin
      p = 15; o = tot - 15;
      if (o > 15) o = 15;
    end else begin
      p = tot; o = 0;
    end
    word = ctlInit;
    word[7:4]  = 4'(p);
    word[11:8] = 4'(o);
  endtask

  task automatic runCase(input bit restart);
    logic [31:0] expWord;
    bit expNl, expNt;
    int expLat, wrBase;
    wrBase = wrTotal;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (restart) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    model(expWord, expNl, expNt, expLat);
    check(done === 1'b1, "R10 done", 32'(done), 32'd1);
    check(wr0Data === expWord, "R7/R8/R9 copy0 word", wr0Data, expWord);
    check(wr1Data === expWord, "R10 copy1 word", wr1Data, expWord);
    check(wrTotal - wrBase == 2, "R10 write count", 32'(wrTotal - wrBase), 32'd2);
    check(int'(gateLat) == expLat, "R5 gateLat", 32'(gateLat), 32'(expLat));
    check(notLeveled === expNl, "R5 notLeveled", 32'(notLeveled), 32'(expNl));
    check(noTrained === expNt, "R6 noTrained", 32'(noTrained), 32'(expNt));
    if (restart) begin
      repeat (6) @(negedge clk);
      check(wrTotal - wrBase == 2 && !busy, "R11 restart ignored", 32'(wrTotal - wrBase), 32'd2);
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) gtr[l] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !ctlWrEn, "R1 control idle", {29'd0, busy, done, ctlWrEn}, 32'd0);
    check(!notLeveled && !noTrained && gateLat == 0, "R1 flags clear",
          {27'd0, notLeveled, noTrained, gateLat}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !ctlWrEn, "R1 idle after release", {30'd0, busy, ctlWrEn}, 32'd0);

    // R3/R4/R6: uniform latencies on every rank, including all-zero
    for (int v = 0; v < 8; v++) begin
      for (int l = 0; l < LANES; l++) gtr[l] = 32'hF000_0000 | {20'd0, {4{3'(v)}}};
      ctlInit = 32'hA5C3_F235;
      runCase(1'b0);
    end

    // R2: only the last lane, top rank, holds a latency
    for (int l = 0; l < LANES; l++) gtr[l] = '0;
    gtr[LANES-1] = 32'(5) << 9;
    ctlInit = 32'h0000_0020;
    runCase(1'b0);

    // R3: each single rank position in lane 0
    for (int r = 0; r < 4; r++) begin
      for (int l = 0; l < LANES; l++) gtr[l] = '0;
      gtr[0] = 32'(3 + r) << (3 * r);
      ctlInit = 32'h1234_5000;
      runCase(1'b0);
    end

    // R7/R8/R9: full sweep of both latency fields with random lanes
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        for (int l = 0; l < LANES; l++) begin
          seed = nextRnd(seed);
          gtr[l] = seed;
        end
        seed = nextRnd(seed);
        ctlInit = seed;
        ctlInit[7:4]  = 4'(a);
        ctlInit[11:8] = 4'(b);
        runCase(1'b0);
      end

    // R4/R5: leveled value with zeros sprinkled in, and random mixes
    for (int n = 0; n < 120; n++) begin
      seed = nextRnd(seed);
      for (int l = 0; l < LANES; l++)
        for (int r = 0; r < 4; r++) begin
          seed = nextRnd(seed);
          gtr[l][3*r +: 3] = seed[0] ? ((n % 2 == 0) ? 3'(1 + n % 7) : seed[3:1]) : 3'd0;
        end
      ctlInit = nextRnd(seed);
      runCase(1'b0);
    end

    // R11: a second start during the pass is ignored
    for (int l = 0; l < LANES; l++) gtr[l] = 32'h0000_0C6A;
    ctlInit = 32'h0000_0F70;
    runCase(1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule